// File: doc/BRIEF.md
# Shadowed compare PWM channel

This block produces one pulse-width-modulated output from an up-counting time base. The counter runs from zero up to a programmable period value, including that value, and then wraps to zero. The output goes high when the counter is at zero. It goes low in the cycle where the counter equals the active compare value. The match is a strict equality test, so a counter that is already past the compare value never clears the output. The block also gives a one-cycle pulse for each compare match and a one-cycle pulse for each cycle in which the running counter is zero.

The active compare value can be written in two ways, chosen by `load_mode`:
- **Immediate** (`load_mode` = 1): a write goes straight to the active register.
- **Shadow** (`load_mode` = 0): a write is parked in a buffer and moves into the active register only at the period wrap.

Shadow loading is meant for changing the duty cycle on the fly. An immediate write that lands below the current count misses its match for the rest of that period.

Output states, all held in `pwm_out_fsm`:
- **ST_IDLE**: the channel is disabled.
- **ST_HIGH**: the output is set.
- **ST_LOW**: the output is cleared.

Transitions:
- *start*: ST_IDLE to ST_HIGH or ST_LOW on the first enabled edge, which counts as a wrap.
- *match*: ST_HIGH to ST_LOW when the counter reaches the active compare value.
- *wrap*: ST_LOW or ST_HIGH to ST_HIGH at counter zero, unless the compare value is also zero, in which case the next state is ST_LOW.
- *stop*: any state to ST_IDLE when `en` is low.

Top module: `pwm_shadow_cmp`

## Requirements
- R1: After reset, `pwm_out`, `cmp_evt` and `zero_evt` are all 0. The active compare value and the shadow buffer both hold 0.
- R2: When `en` rises, the counter reads 0 after the next edge. It then counts 0, 1, …, `period` and wraps to 0, so `zero_evt` is high for one cycle in every `period`+1 cycles.
- R3: `pwm_out` is 1 from the counter-zero cycle up to, but not including, the cycle whose count equals the active compare value. It changes on the same edge that loads that count, so the number of high cycles per period equals the compare value.
- R4: `cmp_evt` is high for exactly the cycles in which the count equals the active compare value, and `pwm_out` is 0 in those cycles.
- R5: With `load_mode` = 0, a write is stored in the shadow buffer and reaches the active register only on the wrap edge. A write made in the cycle where the count equals `period` takes effect one period later.
- R6: With `load_mode` = 1, a write becomes active on the next edge. A write whose value is the next count still matches in that next cycle.
- R7: With `load_mode` = 1, writing a value below the current count gives no `cmp_evt` for the rest of that period, and `pwm_out` stays high until the wrap.
- R8: A compare value of 0 gives 0% duty. `pwm_out` stays low for the whole period and `cmp_evt` pulses in the counter-zero cycle.
- R9: A compare value greater than `period` never matches. `pwm_out` stays high for all `period`+1 cycles and no `cmp_evt` occurs.
- R10: While `en` is 0, `pwm_out`, `cmp_evt` and `zero_evt` stay 0 from the next edge onward. Raising `en` again restarts the period at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable for the time base |
| period | input | CNT_W | Terminal count; the period is this value + 1 cycles |
| cmp_wdata | input | CNT_W | Compare value to write |
| cmp_we | input | 1 | Write strobe for `cmp_wdata` |
| load_mode | input | 1 | 0 = shadow load at wrap, 1 = immediate load |
| pwm_out | output | 1 | Registered PWM level |
| cmp_evt | output | 1 | One-cycle pulse on a compare match |
| zero_evt | output | 1 | One-cycle pulse at counter zero |

## Verification
A wrong count or a stale active compare value changes the number of high cycles in the very next period. It also moves the `cmp_evt` pulse away from its expected index counted from `zero_evt`. Both show at the ports within one period. A broken shadow path shows up as a duty change one period too early or too late. Most directed checks therefore compare the high-cycle count and the first-match index over exactly `period`+1 cycles, taken right after the write under test.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_e;

    typedef enum logic {
        LOAD_SHADOW    = 1'b0,
        LOAD_IMMEDIATE = 1'b1
    } load_mode_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             running,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_n,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // A start from idle is treated as a wrap so that the shadow value loads.
    always_comb begin
        wrap  = en && (!running || (cnt_q >= period));
        cnt_n = cnt_q;
        if (!en || wrap) begin
            cnt_n = '0;
        end else begin
            cnt_n = cnt_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_n;
        end
    end

    // R2: a running counter below the terminal count advances by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running && (cnt_q < period)) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

endmodule

// File: rtl/pwm_cmp_load.sv
module pwm_cmp_load
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  load_mode_e       mode,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wrap,
    output logic [CNT_W-1:0] act_q,
    output logic [CNT_W-1:0] act_n
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] shadow_n;

    always_comb begin
        shadow_n = shadow_q;
        act_n    = act_q;
        unique case (mode)
            LOAD_IMMEDIATE: begin
                if (we) begin
                    act_n = wdata;
                end
            end
            LOAD_SHADOW: begin
                // The old buffer content transfers; a same-cycle write waits.
                if (wrap) begin
                    act_n = shadow_q;
                end
                if (we) begin
                    shadow_n = wdata;
                end
            end
            default: act_n = act_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            shadow_q <= shadow_n;
            act_q    <= act_n;
        end
    end

    // R5: in shadow mode the active value moves only on a wrap edge
    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LOAD_SHADOW && !wrap) |=> $stable(act_q));

    // R6: in immediate mode a write is active after one edge
    a_r6_imm_take: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LOAD_IMMEDIATE && we) |=> (act_q == $past(wdata)));

endmodule

// File: rtl/pwm_out_fsm.sv
module pwm_out_fsm
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_n,
    input  logic [CNT_W-1:0] act_q,
    input  logic [CNT_W-1:0] act_n,
    output logic             running,
    output logic             pwm_out,
    output logic             cmp_evt,
    output logic             zero_evt
);

    pwm_state_e state_q;
    pwm_state_e state_n;
    logic       pwm_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_n = (cnt_n == act_n) ? ST_LOW : ST_HIGH;
                end
            end
            ST_HIGH, ST_LOW: begin
                if (!en) begin
                    state_n = ST_IDLE;
                end else if (cnt_n == act_n) begin
                    state_n = ST_LOW;       // clear wins over set at zero
                end else if (wrap) begin
                    state_n = ST_HIGH;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Registered output level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= (state_n == ST_HIGH);
        end
    end

    assign running  = (state_q != ST_IDLE);
    assign pwm_out  = pwm_q;
    assign cmp_evt  = running && (cnt_q == act_q);
    assign zero_evt = running && (cnt_q == '0);

    // R4: a match cycle always shows a low output
    a_r4_evt_low: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |-> !pwm_out);

    // R3: a zero cycle without a match shows a high output
    a_r3_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !cmp_evt) |-> pwm_out);

    // R10: a disabled channel is quiet after one edge
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_out && !cmp_evt && !zero_evt));

endmodule

// File: rtl/pwm_shadow_cmp.sv
module pwm_shadow_cmp
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cmp_we,
    input  logic             load_mode,
    output logic             pwm_out,
    output logic             cmp_evt,
    output logic             zero_evt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] act_n;
    logic             wrap;
    logic             running;
    load_mode_e       mode;

    assign mode = load_mode_e'(load_mode);

    pwm_timebase #(.CNT_W(CNT_W)) tb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .running (running),
        .period  (period),
        .cnt_q   (cnt_q),
        .cnt_n   (cnt_n),
        .wrap    (wrap)
    );

    pwm_cmp_load #(.CNT_W(CNT_W)) ld_i (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .we    (cmp_we),
        .wdata (cmp_wdata),
        .wrap  (wrap),
        .act_q (act_q),
        .act_n (act_n)
    );

    pwm_out_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .wrap     (wrap),
        .cnt_q    (cnt_q),
        .cnt_n    (cnt_n),
        .act_q    (act_q),
        .act_n    (act_n),
        .running  (running),
        .pwm_out  (pwm_out),
        .cmp_evt  (cmp_evt),
        .zero_evt (zero_evt)
    );

endmodule

// File: tb/pwm_shadow_cmp_tb.sv
`timescale 1ns/1ps
module pwm_shadow_cmp_tb_top;

    localparam int CNT_W = 16;
    localparam int NVEC  = 9;
    // {period, compare, expected high cycles, expected match count}
    localparam int VEC [NVEC][4] = '{
        '{7, 3, 3, 1},
        '{7, 0, 0, 1},    // R8
        '{7, 7, 7, 1},
        '{7, 8, 8, 0},    // R9
        '{4, 2, 2, 1},
        '{12, 20, 13, 0}, // R9
        '{1, 1, 1, 1},
        '{0, 0, 0, 1},    // R8
        '{0, 1, 1, 0}     // R9
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [CNT_W-1:0] period = '0;
    logic [CNT_W-1:0] cmp_wdata = '0;
    logic             cmp_we = 1'b0;
    logic             load_mode = 1'b0;
    logic             pwm_out;
    logic             cmp_evt;
    logic             zero_evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_shadow_cmp #(.CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .period    (period),
        .cmp_wdata (cmp_wdata),
        .cmp_we    (cmp_we),
        .load_mode (load_mode),
        .pwm_out   (pwm_out),
        .cmp_evt   (cmp_evt),
        .zero_evt  (zero_evt)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge inside a counter-zero cycle; returns at the next one.
    task automatic run_period(input int per, input bit do_wr, input int wr_at,
                              input int wr_val, output int hi, output int evts,
                              output int first_evt, output int zeros);
        hi = 0; evts = 0; first_evt = -1; zeros = 0;
        for (int i = 0; i <= per; i++) begin
            if (pwm_out) hi++;
            if (cmp_evt) begin
                evts++;
                if (first_evt < 0) first_evt = i;
            end
            if (zero_evt) zeros++;
            if (do_wr && i == wr_at) begin
                cmp_we = 1'b1;
                cmp_wdata = CNT_W'(wr_val);
            end else begin
                cmp_we = 1'b0;
            end
            @(negedge clk);
        end
        cmp_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, evts, fe, zs, gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pwm_out", int'(pwm_out), 0);
        check("R1 cmp_evt", int'(cmp_evt), 0);
        check("R1 zero_evt", int'(zero_evt), 0);

        // Table walk, shadow mode, configured while disabled
        for (int v = 0; v < NVEC; v++) begin
            en = 1'b0;
            load_mode = 1'b0;
            period = CNT_W'(VEC[v][0]);
            cmp_wdata = CNT_W'(VEC[v][1]);
            cmp_we = 1'b1;
            @(negedge clk);
            cmp_we = 1'b0;
            en = 1'b1;
            @(negedge clk);
            check("R2 zero at start", int'(zero_evt), 1);
            run_period(VEC[v][0], 1'b0, 0, 0, hi, evts, fe, zs);
            check("R3 high cycles", hi, VEC[v][2]);
            check("R4 match count", evts, VEC[v][3]);
            check("R2 one zero per period", zs, 1);
            if (VEC[v][3] == 1) check("R3 match index", fe, VEC[v][1]);
            check("R2 zero after wrap", int'(zero_evt), 1);
        end

        // R2: spacing of zero pulses
        en = 1'b0;
        period = 16'd5;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!zero_evt && gap < 50);
        check("R2 zero spacing", gap, 6);

        // R5: shadow loading
        en = 1'b0;
        period = 16'd9;
        load_mode = 1'b0;
        cmp_wdata = 16'd3;
        cmp_we = 1'b1;
        @(negedge clk);
        cmp_we = 1'b0;
        en = 1'b1;
        @(negedge clk);
        run_period(9, 1'b1, 2, 7, hi, evts, fe, zs);
        check("R5 mid-period write held", hi, 3);
        run_period(9, 1'b0, 0, 0, hi, evts, fe, zs);
        check("R5 value loaded at wrap", hi, 7);
        run_period(9, 1'b1, 9, 5, hi, evts, fe, zs);
        check("R5 wrap-cycle write period", hi, 7);
        run_period(9, 1'b0, 0, 0, hi, evts, fe, zs);
        check("R5 wrap-cycle write deferred", hi, 7);
        run_period(9, 1'b0, 0, 0, hi, evts, fe, zs);
        check("R5 deferred value active", hi, 5);

        // R6: immediate loading (active value is 5 here)
        load_mode = 1'b1;
        run_period(9, 1'b1, 3, 4, hi, evts, fe, zs);
        check("R6 immediate high cycles", hi, 4);
        check("R6 immediate match index", fe, 4);
        run_period(9, 1'b1, 2, 3, hi, evts, fe, zs);
        check("R6 next-count write matches", fe, 3);
        check("R6 next-count high cycles", hi, 3);

        // R7: write below the current count
        run_period(9, 1'b1, 0, 8, hi, evts, fe, zs);
        check("R7 setup high cycles", hi, 8);
        run_period(9, 1'b1, 5, 4, hi, evts, fe, zs);
        check("R7 missed match count", evts, 0);
        check("R7 output held high", hi, 10);
        run_period(9, 1'b0, 0, 0, hi, evts, fe, zs);
        check("R7 new value next period", hi, 4);

        // R10: disable and restart
        en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 pwm low while off", int'(pwm_out), 0);
            check("R10 no match while off", int'(cmp_evt), 0);
            check("R10 no zero while off", int'(zero_evt), 0);
        end
        en = 1'b1;
        @(negedge clk);
        check("R10 restart zero", int'(zero_evt), 1);
        check("R10 restart high", int'(pwm_out), 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule